// File: doc/BRIEF.md
# DRAM refresh and initialization scheduler

This block keeps an asynchronous DRAM alive on behalf of the memory controller. After reset it waits a fixed pause and then runs a series of wake-up refresh cycles. Only then does it report the interface ready. From that point it counts a refresh interval. Each expiry adds one refresh to a pending count, and the block issues each pending refresh as a CAS-before-RAS cycle, where CAS falls before RAS. The device's internal row counter supplies the row, so the block drives no address, write-enable or output-enable signals. Both byte CAS strobes move together.

The block shares the RAS and CAS pins with an access sequencer. It raises `bus_req` whenever it has work or a cycle is running. It starts a cycle only in a clock where `grant` is high. Once a cycle has started it always runs to completion. Refreshes that were held back while the bus was busy are issued back to back once the bus is granted.

On request the block can park the DRAM in self-refresh. The normal cycle is turned into a long RAS/CAS-low hold with a minimum length, and on exit the block precharges for a fixed time. Distributed refresh then resumes with nothing owed. If the DRAM goes too long without a completed refresh, the block drops ready and repeats the wake-up series. All times are parameters in clock cycles.

Top module: `dram_refresh_sched`

## Requirements
- R1: For INIT_WAIT clock cycles after reset release, `ras_n`, `lcas_n` and `ucas_n` stay high and `ready` and `bus_req` stay low.
- R2: After the pause, exactly WAKE_CYCLES refresh cycles are issued. `ready` rises in the cycle after the precharge of the last of them ends, and not before.
- R3: A refresh cycle drives CAS low for T_CSR cycles with RAS high, then holds both low for T_CHR cycles, then holds RAS alone low for T_RAS cycles, then holds both high for T_RP cycles. RAS never falls while CAS is high.
- R4: `lcas_n` and `ucas_n` are identical in every cycle.
- R5: While ready and not in self-refresh, one refresh becomes pending every REF_INTERVAL cycles. The interval counting starts from the first ready cycle, so the first pending refresh is visible REF_INTERVAL cycles after `ready` rises. `pend_count` shows the number pending.
- R6: A cycle starts only in an idle clock with `grant` high, and `bus_req` stays high while any cycle runs or work is owed. With `grant` low no strobe moves. Pending refreshes are issued back to back with one idle cycle between them, and each completed cycle lowers `pend_count` by one.
- R7: `pend_count` never exceeds MAX_PEND. An interval expiry that finds the count full sets `overflow`, which stays set until reset.
- R8: If `self_ref_req` is high while ready at the last cycle of the RAS/CAS overlap, both strobes stay low for at least T_RASS cycles and until `self_ref_req` falls. Both strobes are then high for T_RPS cycles while `self_ref_active` is still high. `self_ref_active` covers that whole span. On exit the pending count is cleared and the interval restarts.
- R9: If LAPSE_LIMIT cycles pass while ready without a completed refresh, `ready` drops, the pending count clears, and WAKE_CYCLES refresh cycles are issued again before `ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant | input | 1 | Bus granted to this block; must stay high while `bus_req` is high and a cycle runs |
| self_ref_req | input | 1 | Level request to enter and stay in self-refresh |
| bus_req | output | 1 | Request for the shared RAS/CAS pins |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower byte column strobe, active low |
| ucas_n | output | 1 | Upper byte column strobe, active low |
| ready | output | 1 | Initialization done; normal accesses allowed |
| self_ref_active | output | 1 | High from self-refresh entry until its exit precharge ends |
| pend_count | output | $clog2(MAX_PEND+1) | Number of refreshes owed |
| overflow | output | 1 | Sticky: an interval expired with the pending count full |

## Verification
The grant line is the main stimulus. Holding it high lets every owed refresh go out at once. Withholding it for a few intervals separates correct accumulation and saturation from a counter that wraps or drops ticks, and withholding it past the lapse limit forces a second wake-up series. A self-refresh request is placed over a pending backlog, so that clearing on exit and the minimum low hold are both seen, and the strobe shape is compared cycle by cycle against an independent position-based model.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {PH_PAUSE, PH_WAKE, PH_RUN} phase_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CAS_LEAD, ST_OVERLAP, ST_RAS_TAIL, ST_PRECH, ST_SELF, ST_SELF_EXIT
  } strobe_t;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // pending refresh count after one clock: saturating add, floor at zero
  function automatic int next_pending(int cnt, bit inc, bit dec, int limit);
    int n;
    n = cnt + (inc ? 1 : 0) - (dec ? 1 : 0);
    if (n < 0) n = 0;
    if (n > limit) n = limit;
    return n;
  endfunction

  // an expiry is lost when the count is already full and nothing drains
  function automatic bit pending_lost(int cnt, bit inc, bit dec, int limit);
    return inc && !dec && (cnt >= limit);
  endfunction

endpackage

// File: rtl/ref_interval_ctr.sv
module ref_interval_ctr #(
  parameter int LIMIT = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;
  logic at_end;

  assign at_end = (cnt == CW'(LIMIT - 1));
  assign hit    = en && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!en || clr || at_end) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ref_pend_ctr.sv
module ref_pend_ctr
  import dram_ref_pkg::*;
#(
  parameter int MAX_PEND = 8,
  localparam int PW = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          dec,
  input  logic          clr,
  output logic [PW-1:0] count,
  output logic          overflow
);
  logic lost;
  assign lost = !clr && pending_lost(int'(count), tick, dec, MAX_PEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (clr) count <= '0;
      else count <= PW'(next_pending(int'(count), tick, dec, MAX_PEND));
      if (lost) overflow <= 1'b1;
    end
  end

  AST_PEND_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= MAX_PEND); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overflow) |-> overflow); // R7
endmodule

// File: rtl/cbr_strobe_fsm.sv
module cbr_strobe_fsm
  import dram_ref_pkg::*;
#(
  parameter int T_CSR  = 1,
  parameter int T_CHR  = 1,
  parameter int T_RAS  = 3,
  parameter int T_RP   = 2,
  parameter int T_RASS = 5000,
  parameter int T_RPS  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic self_go,
  output logic ras_n,
  output logic cas_n,
  output logic idle,
  output logic done_norm,
  output logic done_self,
  output logic self_active
);
  localparam int LMAX = max2(max2(max2(T_CSR, T_CHR), max2(T_RAS, T_RP)), max2(T_RASS, T_RPS));
  localparam int CW   = $clog2(LMAX + 1);

  strobe_t st;
  logic [CW-1:0] cnt;
  logic last;

  assign last        = (cnt == '0);
  assign idle        = (st == ST_IDLE);
  assign done_norm   = (st == ST_PRECH) && last;
  assign done_self   = (st == ST_SELF_EXIT) && last;
  assign self_active = (st == ST_SELF) || (st == ST_SELF_EXIT);
  assign ras_n = !((st == ST_OVERLAP) || (st == ST_RAS_TAIL) || (st == ST_SELF));
  assign cas_n = !((st == ST_CAS_LEAD) || (st == ST_OVERLAP) || (st == ST_SELF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st <= ST_CAS_LEAD; cnt <= CW'(T_CSR - 1);
        end
        ST_CAS_LEAD: if (last) begin
          st <= ST_OVERLAP; cnt <= CW'(T_CHR - 1);
        end else cnt <= cnt - 1'b1;
        ST_OVERLAP: if (last) begin
          if (self_go) begin st <= ST_SELF; cnt <= CW'(T_RASS - 1); end
          else begin st <= ST_RAS_TAIL; cnt <= CW'(T_RAS - 1); end
        end else cnt <= cnt - 1'b1;
        ST_RAS_TAIL: if (last) begin
          st <= ST_PRECH; cnt <= CW'(T_RP - 1);
        end else cnt <= cnt - 1'b1;
        ST_PRECH: if (last) st <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        ST_SELF: if (last) begin
          if (!self_go) begin st <= ST_SELF_EXIT; cnt <= CW'(T_RPS - 1); end
        end else cnt <= cnt - 1'b1;
        ST_SELF_EXIT: if (last) st <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n))); // R3
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int INIT_WAIT    = 10000,
  parameter int WAKE_CYCLES  = 8,
  parameter int REF_INTERVAL = 780,
  parameter int LAPSE_LIMIT  = 6240,
  parameter int MAX_PEND     = 8,
  parameter int T_CSR        = 1,
  parameter int T_CHR        = 1,
  parameter int T_RAS        = 3,
  parameter int T_RP         = 2,
  parameter int T_RASS       = 5000,
  parameter int T_RPS        = 5,
  localparam int PW = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grant,
  input  logic          self_ref_req,
  output logic          bus_req,
  output logic          ras_n,
  output logic          lcas_n,
  output logic          ucas_n,
  output logic          ready,
  output logic          self_ref_active,
  output logic [PW-1:0] pend_count,
  output logic          overflow
);
  localparam int PCW = $clog2(INIT_WAIT + 1);
  localparam int WKW = $clog2(WAKE_CYCLES + 1);

  phase_t ph;
  logic [PCW-1:0] pause_cnt;
  logic [WKW-1:0] wake_left;

  logic run, self_go, want, start, idle;
  logic done_norm, done_self, done_any;
  logic timer_en, tick, lapse_hit, lapse;
  logic cas_n;

  assign run      = (ph == PH_RUN);
  assign self_go  = self_ref_req && run;
  assign want     = (ph == PH_WAKE) || (run && ((pend_count != '0) || self_ref_req));
  assign start    = idle && grant && want;
  assign done_any = done_norm || done_self;
  assign timer_en = run && !self_ref_active;
  assign lapse    = lapse_hit && !done_any;

  assign bus_req = !idle || want;
  assign ready   = run;
  assign lcas_n  = cas_n;
  assign ucas_n  = cas_n;

  cbr_strobe_fsm #(
    .T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_RASS(T_RASS), .T_RPS(T_RPS)
  ) i_strobe (
    .clk(clk), .rst_n(rst_n), .start(start), .self_go(self_go),
    .ras_n(ras_n), .cas_n(cas_n), .idle(idle),
    .done_norm(done_norm), .done_self(done_self), .self_active(self_ref_active)
  );

  ref_interval_ctr #(.LIMIT(REF_INTERVAL)) i_tick (
    .clk(clk), .rst_n(rst_n), .en(timer_en), .clr(1'b0), .hit(tick)
  );

  ref_interval_ctr #(.LIMIT(LAPSE_LIMIT)) i_lapse (
    .clk(clk), .rst_n(rst_n), .en(timer_en), .clr(done_any), .hit(lapse_hit)
  );

  ref_pend_ctr #(.MAX_PEND(MAX_PEND)) i_pend (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dec(done_norm && run),
    .clr(done_self || lapse), .count(pend_count), .overflow(overflow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_PAUSE;
      pause_cnt <= '0;
      wake_left <= '0;
    end else begin
      case (ph)
        PH_PAUSE: if (pause_cnt == PCW'(INIT_WAIT - 1)) begin
          ph <= PH_WAKE; wake_left <= WKW'(WAKE_CYCLES);
        end else pause_cnt <= pause_cnt + 1'b1;
        PH_WAKE: if (done_norm) begin
          if (wake_left == WKW'(1)) ph <= PH_RUN;
          wake_left <= wake_left - 1'b1;
        end
        PH_RUN: if (lapse) begin
          ph <= PH_WAKE; wake_left <= WKW'(WAKE_CYCLES);
        end
        default: ph <= PH_PAUSE;
      endcase
    end
  end

  AST_QUIET_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_PAUSE) |-> (ras_n && lcas_n && ucas_n && !bus_req)); // R1
  AST_READY_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(done_norm)); // R2
  AST_START_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcas_n) |-> $past(grant)); // R6
  AST_BYTE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcas_n) |-> $fell(ucas_n)); // R4
endmodule

// File: tb/test_dram_refresh_sched.sv
module test_dram_refresh_sched;
  localparam int IW = 20, WC = 8, RI = 40, LL = 600, MP = 8;
  localparam int CSR = 1, CHR = 2, RAS = 2, RP = 2, RASS = 30, RPS = 3;
  localparam int L = CSR + CHR + RAS + RP;

  logic clk = 1'b0, rst_n = 1'b0, grant = 1'b1, self_ref_req = 1'b0;
  logic bus_req, ras_n, lcas_n, ucas_n, ready, self_ref_active, overflow;
  logic [3:0] pend_count;

  always #10 clk = ~clk;

  dram_refresh_sched #(
    .INIT_WAIT(IW), .WAKE_CYCLES(WC), .REF_INTERVAL(RI), .LAPSE_LIMIT(LL),
    .MAX_PEND(MP), .T_CSR(CSR), .T_CHR(CHR), .T_RAS(RAS), .T_RP(RP),
    .T_RASS(RASS), .T_RPS(RPS)
  ) i_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .grant(grant), .self_ref_req(self_ref_req),
    .bus_req(bus_req), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .ready(ready), .self_ref_active(self_ref_active),
    .pend_count(pend_count), .overflow(overflow)
  );

  int n_vec = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 pause, 1 wake, 2 run; pos = place in a refresh cycle
  int m_ph, m_pc, m_wk, m_pos, m_sc, m_rps, m_tc, m_lc, m_pend;
  bit m_self, m_ovf, armed;

  always @(posedge clk) begin
    bit idle, sact, run, want, st, dn, ds, en, tk, lp, dec, clr;
    if (!rst_n) begin
      m_ph = 0; m_pc = 0; m_wk = 0; m_pos = -1; m_sc = 0; m_rps = -1;
      m_tc = 0; m_lc = 0; m_pend = 0; m_self = 0; m_ovf = 0; armed = 0;
    end else begin
      armed = 1;
      idle = (m_pos < 0) && !m_self && (m_rps < 0);
      sact = m_self || (m_rps >= 0);
      run  = (m_ph == 2);
      want = (m_ph == 1) || (run && (m_pend != 0 || self_ref_req));
      st   = idle && grant && want;
      dn   = (m_pos == L - 1);
      ds   = (m_rps == RPS - 1);
      en   = run && !sact;
      tk   = en && (m_tc == RI - 1);
      lp   = en && (m_lc == LL - 1) && !(dn || ds);
      dec  = dn && run;
      clr  = ds || lp;
      if (clr) m_pend = 0;
      else begin
        if (tk && m_pend == MP && !dec) m_ovf = 1;
        m_pend = m_pend + (tk ? 1 : 0) - (dec ? 1 : 0);
        if (m_pend < 0) m_pend = 0;
        if (m_pend > MP) m_pend = MP;
      end
      m_tc = (!en || tk) ? 0 : m_tc + 1;
      m_lc = (!en || dn || ds || m_lc == LL - 1) ? 0 : m_lc + 1;
      if (st) m_pos = 0;
      else if (m_pos >= 0) begin
        if (m_pos == CSR + CHR - 1 && self_ref_req && run) begin
          m_pos = -1; m_self = 1; m_sc = 1;
        end else if (m_pos == L - 1) m_pos = -1;
        else m_pos++;
      end else if (m_self) begin
        if (m_sc >= RASS && !self_ref_req) begin m_self = 0; m_rps = 0; end
        else m_sc++;
      end else if (m_rps >= 0) begin
        if (m_rps == RPS - 1) m_rps = -1; else m_rps++;
      end
      case (m_ph)
        0: if (m_pc == IW - 1) begin m_ph = 1; m_wk = WC; end else m_pc++;
        1: if (dn) begin if (m_wk == 1) m_ph = 2; m_wk--; end
        2: if (lp) begin m_ph = 1; m_wk = WC; end
        default: ;
      endcase
    end
  end

  int falls = 0;
  logic prev_ras = 1'b1;

  always @(negedge clk) begin
    bit e_ras_lo, e_cas_lo, e_idle, e_want, e_req, e_sact;
    if (prev_ras && !ras_n) falls++;
    prev_ras = ras_n;
    if (armed) begin
      e_cas_lo = (m_pos >= 0 && m_pos < CSR + CHR) || m_self;
      e_ras_lo = (m_pos >= CSR && m_pos < CSR + CHR + RAS) || m_self;
      e_idle = (m_pos < 0) && !m_self && (m_rps < 0);
      e_sact = m_self || (m_rps >= 0);
      e_want = (m_ph == 1) || (m_ph == 2 && (m_pend != 0 || self_ref_req));
      e_req  = !e_idle || e_want;
      chk(ras_n == !e_ras_lo, "R3 ras_n", ras_n, !e_ras_lo);
      chk(lcas_n == !e_cas_lo, "R3 lcas_n", lcas_n, !e_cas_lo);
      chk(ucas_n == lcas_n, "R4 ucas_n", ucas_n, lcas_n);
      chk(ready == (m_ph == 2), "R2 ready", ready, m_ph == 2);
      chk(bus_req == e_req, "R6 bus_req", bus_req, e_req);
      chk(int'(pend_count) == m_pend, "R5 pend_count", pend_count, m_pend);
      chk(overflow == m_ovf, "R7 overflow", overflow, m_ovf);
      chk(self_ref_active == e_sact, "R8 self_ref_active", self_ref_active, e_sact);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  task automatic wait_for(input int limit, input string what, ref logic sig, input logic val);
    int k = 0;
    while (sig !== val && k < limit) begin @(negedge clk); k++; end
    chk(sig === val, what, sig, val);
  endtask

  initial begin
    int t, f0;
    repeat (3) @(negedge clk);
    chk(ras_n && lcas_n && !ready && !bus_req, "R1 reset state", ras_n, 1);
    rst_n = 1'b1;
    t = 0;
    while (!bus_req && t < 200) begin @(negedge clk); t++; end
    chk(t >= IW, "R1 quiet pause length", t, IW);
    chk(falls == 0, "R1 no strobe in pause", falls, 0);
    wait_for(500, "R2 ready rises", ready, 1'b1);
    chk(falls == WC, "R2 wake cycle count", falls, WC);
    grant = 1'b0;
    repeat (RI - 1) @(negedge clk);
    chk(pend_count == 0, "R5 no tick before interval", pend_count, 0);
    @(negedge clk);
    chk(pend_count == 1, "R5 first tick", pend_count, 1);
    f0 = falls;
    repeat (400) @(negedge clk);
    chk(falls == f0, "R6 no cycle without grant", falls, f0);
    chk(pend_count == MP, "R7 saturates", pend_count, MP);
    chk(overflow == 1'b1, "R7 overflow set", overflow, 1);
    grant = 1'b1;
    t = 0;
    while (pend_count != 0 && t < 500) begin @(negedge clk); t++; end
    chk(pend_count == 0, "R6 backlog drained", pend_count, 0);
    chk(overflow == 1'b1, "R7 overflow sticky", overflow, 1);
    grant = 1'b0;
    repeat (20) @(negedge clk);
    grant = 1'b1;
    self_ref_req = 1'b1;
    wait_for(200, "R8 self entered", self_ref_active, 1'b1);
    repeat (RASS + 20) @(negedge clk);
    chk(!ras_n && !lcas_n, "R8 strobes held low", ras_n, 0);
    self_ref_req = 1'b0;
    wait_for(RPS + 10, "R8 self exit", self_ref_active, 1'b0);
    chk(pend_count == 0 && ready && ras_n, "R8 clean exit", pend_count, 0);
    grant = 1'b0;
    repeat (LL + 100) @(negedge clk);
    chk(ready == 1'b0, "R9 lapse drops ready", ready, 0);
    chk(pend_count == 0, "R9 lapse clears pending", pend_count, 0);
    falls = 0;
    grant = 1'b1;
    wait_for(500, "R9 ready returns", ready, 1'b1);
    chk(falls == WC, "R9 wake repeated", falls, WC);
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule